// File: doc/BRIEF.md
# Four-Layer Cascaded Alpha Compositor

The compositor produces a frame of 32-bit pixels by stacking up to four image layers over a programmable background colour. It walks the output raster on its own, left to right and top to bottom. For every output coordinate it tells each layer whether that layer covers the pixel, and it takes that layer's next pixel in the same cycle. It then emits one finished pixel per cycle on a valid/ready stream that carries end-of-line and end-of-frame markers.

Four blend stages form a fixed chain. The first stage blends layer 0 over the background colour. Each later stage blends the next layer over the result of the stage before it, so layer 3 ends up on top. The second stage takes its layer through a raster-operation path that is fixed to pass the pixel through unchanged.

Each layer has four settings: an enable, a premultiplied-alpha flag, a placement offset and a size. There is no scaling, so a layer covers exactly as many output pixels as it supplies. Pixel words hold alpha in bits 31:24 and three colour channels in bits 23:16, 15:8 and 7:0. The arithmetic treats every channel alike, so RGB and YUV data are handled the same way.

Top module: `layer_compositor`

## Requirements
- R1: For a covered, non-premultiplied layer with source alpha `sa`, each colour channel becomes `rnd(d*(255-sa)/255) + rnd(s*sa/255)`. Here `rnd` rounds to the nearest integer and the sum saturates at 255.
- R2: For a covered, premultiplied layer, each colour channel becomes `rnd(d*(255-sa)/255) + s`, saturated at 255. The source colour is not multiplied.
- R3: For any covered layer, whether premultiplied or not, the alpha byte becomes `rnd(da*(255-sa)/255) + sa`.
- R4: The destination of the first stage is `bg_color`, which covers the whole output frame from coordinate (0,0).
- R5: Layers are applied in index order, 0 first and 3 last. Layer 1 reaches its stage unchanged.
- R6: A disabled layer never has its `lyr_req` bit raised and does not change any output pixel.
- R7: A layer's x offset is clamped to `frame_w-1` and its y offset to `frame_h-1`. The layer covers `lyr_w` by `lyr_h` pixels from that corner, cut at the frame edge. Pixels outside that rectangle pass through unchanged.
- R8: `lyr_req[i]` is high in exactly those cycles in which output coordinates covered by layer i are issued, in raster order. The word on `lyr_pix[32*i+31:32*i]` is consumed at that clock edge.
- R9: Pixels leave in raster order. `out_eol` marks the last pixel of each line, and `out_eof` marks the last pixel of the frame, on which `out_eol` is also set. `frame_w` and `frame_h` may range from 1 to 4095.
- R10: All configuration inputs are sampled once, before the first pixel of each frame. Changes made during a frame do not affect that frame.
- R11: While `out_valid` is high and `out_ready` is low, `out_pix`, `out_eol` and `out_eof` hold steady and `lyr_req` stays low. No pixel is lost or repeated.
- R12: While `rst_n` is low, `out_valid` and `lyr_req` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_w | input | 12 | Output width in pixels (1..4095) |
| frame_h | input | 12 | Output height in lines (1..4095) |
| bg_color | input | 32 | Background pixel (alpha in bits 31:24) |
| lyr_en | input | 4 | Per-layer enable |
| lyr_pm | input | 4 | Per-layer premultiplied-alpha flag |
| lyr_x | input | 48 | Per-layer x offset, 12 bits per layer, layer i at bits 12i+11:12i |
| lyr_y | input | 48 | Per-layer y offset, same packing |
| lyr_w | input | 48 | Per-layer width, same packing |
| lyr_h | input | 48 | Per-layer height, same packing |
| lyr_pix | input | 128 | Current pixel of each layer, layer i at bits 32i+31:32i |
| lyr_req | output | 4 | Per-layer take strobe for the current pixel |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_pix | output | 32 | Composited pixel |
| out_eol | output | 1 | Last pixel of a line |
| out_eof | output | 1 | Last pixel of the frame |

## Verification
Suppose the raster counters or the clamped placement registers hold a wrong value. Then a layer is requested one pixel early or late. From that cycle onward, every later pixel of that layer in the frame is shifted, so the error shows in the output stream about four cycles later and does not go away. A wrong stage enable or premultiplied bit damages only the pixels that layer covers, and it does so in the first such pixel to leave the chain. A fault in the stall path shows up at the next output cycle as a changed, dropped or repeated pixel. A stale configuration register shows up in the first pixel of the frame it should have set up.

// File: rtl/layer_compositor.sv
module layer_compositor #(
  parameter int DIM_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DIM_W-1:0]   frame_w,
  input  logic [DIM_W-1:0]   frame_h,
  input  logic [31:0]        bg_color,
  input  logic [3:0]         lyr_en,
  input  logic [3:0]         lyr_pm,
  input  logic [4*DIM_W-1:0] lyr_x,
  input  logic [4*DIM_W-1:0] lyr_y,
  input  logic [4*DIM_W-1:0] lyr_w,
  input  logic [4*DIM_W-1:0] lyr_h,
  input  logic [127:0]       lyr_pix,
  output logic [3:0]         lyr_req,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [31:0]        out_pix,
  output logic               out_eol,
  output logic               out_eof
);
  localparam int NL = 4;
  localparam int PW = 32;

  function automatic logic [7:0] div255(input logic [15:0] p);
    logic [15:0] t;
    t = p + 16'd128;
    t = t + (t >> 8);
    return 8'(t >> 8);
  endfunction

  function automatic logic [31:0] blend(input logic [31:0] d, input logic [31:0] s,
                                        input logic on, input logic pm);
    logic [7:0]  sa, ia;
    logic [8:0]  sum;
    logic [31:0] r;
    sa  = s[31:24];
    ia  = 8'd255 - sa;
    sum = {1'b0, div255(16'(d[31:24]) * 16'(ia))} + {1'b0, sa};
    r[31:24] = sum[8] ? 8'hff : sum[7:0];
    for (int c = 0; c < 3; c++) begin
      sum = {1'b0, div255(16'(d[8*c +: 8]) * 16'(ia))}
          + {1'b0, pm ? s[8*c +: 8] : div255(16'(s[8*c +: 8]) * 16'(sa))};
      r[8*c +: 8] = sum[8] ? 8'hff : sum[7:0];
    end
    return on ? r : d;
  endfunction

  logic             load_q;
  logic [DIM_W-1:0] x_q, y_q, w_s, h_s;
  logic [31:0]      bg_s;
  logic [NL-1:0]    en_s, pm_s, cov;
  logic [DIM_W-1:0] lx_s [NL];
  logic [DIM_W-1:0] ly_s [NL];
  logic [DIM_W-1:0] lw_s [NL];
  logic [DIM_W-1:0] lh_s [NL];

  logic adv, issue, last_x, last_y;

  logic [3:0]       v_q, eol_q, eof_q;
  logic [31:0]      acc_a, acc_b, acc_c, acc_d;
  logic [3*PW-1:0]  car_a;
  logic [2*PW-1:0]  car_b;
  logic [PW-1:0]    car_c;
  logic [2:0]       on_a, pmk_a;
  logic [1:0]       on_b, pmk_b;
  logic             on_c, pmk_c;

  assign adv       = !v_q[3] || out_ready;
  assign issue     = adv && !load_q;
  assign last_x    = x_q == w_s - 1'b1;
  assign last_y    = y_q == h_s - 1'b1;
  assign lyr_req   = issue ? cov : '0;
  assign out_valid = v_q[3];
  assign out_pix   = acc_d;
  assign out_eol   = eol_q[3];
  assign out_eof   = eof_q[3];

  always_comb begin
    for (int i = 0; i < NL; i++)
      cov[i] = en_s[i] && x_q >= lx_s[i] && y_q >= ly_s[i]
            && ({1'b0, x_q} < {1'b0, lx_s[i]} + {1'b0, lw_s[i]})
            && ({1'b0, y_q} < {1'b0, ly_s[i]} + {1'b0, lh_s[i]});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_s  <= '0;
      h_s  <= '0;
      bg_s <= '0;
      en_s <= '0;
      pm_s <= '0;
      for (int i = 0; i < NL; i++) begin
        lx_s[i] <= '0;
        ly_s[i] <= '0;
        lw_s[i] <= '0;
        lh_s[i] <= '0;
      end
    end else if (load_q) begin
      w_s  <= frame_w;
      h_s  <= frame_h;
      bg_s <= bg_color;
      en_s <= lyr_en;
      pm_s <= lyr_pm;
      for (int i = 0; i < NL; i++) begin
        lx_s[i] <= (lyr_x[i*DIM_W +: DIM_W] >= frame_w) ? frame_w - 1'b1 : lyr_x[i*DIM_W +: DIM_W];
        ly_s[i] <= (lyr_y[i*DIM_W +: DIM_W] >= frame_h) ? frame_h - 1'b1 : lyr_y[i*DIM_W +: DIM_W];
        lw_s[i] <= lyr_w[i*DIM_W +: DIM_W];
        lh_s[i] <= lyr_h[i*DIM_W +: DIM_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q    <= '0;
      y_q    <= '0;
      load_q <= 1'b1;
    end else if (load_q) begin
      load_q <= 1'b0;
    end else if (issue) begin
      if (last_x) begin
        x_q <= '0;
        if (last_y) begin
          y_q    <= '0;
          load_q <= 1'b1;
        end else begin
          y_q <= y_q + 1'b1;
        end
      end else begin
        x_q <= x_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= '0;
      eol_q <= '0;
      eof_q <= '0;
      acc_a <= '0;
      acc_b <= '0;
      acc_c <= '0;
      acc_d <= '0;
      car_a <= '0;
      car_b <= '0;
      car_c <= '0;
      on_a  <= '0;
      on_b  <= '0;
      on_c  <= 1'b0;
      pmk_a <= '0;
      pmk_b <= '0;
      pmk_c <= 1'b0;
    end else if (adv) begin
      v_q   <= {v_q[2:0], issue};
      eol_q <= {eol_q[2:0], last_x};
      eof_q <= {eof_q[2:0], last_x && last_y};
      // stage A: layer 0 over the background source
      acc_a <= blend(bg_s, lyr_pix[PW-1:0], cov[0], pm_s[0]);
      car_a <= lyr_pix[NL*PW-1:PW];
      on_a  <= cov[3:1];
      pmk_a <= pm_s[3:1];
      // stage B: layer 1 arrives through the pass-through raster-op path
      acc_b <= blend(acc_a, car_a[PW-1:0], on_a[0], pmk_a[0]);
      car_b <= car_a[3*PW-1:PW];
      on_b  <= on_a[2:1];
      pmk_b <= pmk_a[2:1];
      acc_c <= blend(acc_b, car_b[PW-1:0], on_b[0], pmk_b[0]);
      car_c <= car_b[2*PW-1:PW];
      on_c  <= on_b[1];
      pmk_c <= pmk_b[1];
      acc_d <= blend(acc_c, car_c, on_c, pmk_c);
    end
  end
endmodule

// File: rtl/layer_compositor_chk.sv
module layer_compositor_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_pix,
  input logic        out_eol,
  input logic        out_eof,
  input logic [3:0]  lyr_req
);
  assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pix) && $stable(out_eol) && $stable(out_eof));

  assert_no_take_in_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> lyr_req == 4'b0000);

  assert_eof_implies_eol_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_eof |-> out_eol);

  assert_reset_idle_R12: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

  always @(negedge clk) begin
    if (!rst_n) assert_reset_noreq_R12: assert (lyr_req == 4'b0000);
  end
endmodule

bind layer_compositor layer_compositor_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_pix   (out_pix),
  .out_eol   (out_eol),
  .out_eof   (out_eof),
  .lyr_req   (lyr_req)
);

// File: tb/sim_layer_compositor.sv
module sim_layer_compositor;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [11:0]  frame_w, frame_h;
  logic [31:0]  bg_color;
  logic [3:0]   lyr_en, lyr_pm;
  logic [47:0]  lyr_x, lyr_y, lyr_w, lyr_h;
  logic [127:0] lyr_pix;
  logic [3:0]   lyr_req;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [31:0]  out_pix;
  logic         out_eol, out_eof;

  int checks = 0;
  int fails  = 0;

  int          c_w, c_h;
  logic [31:0] c_bg;
  logic [3:0]  c_en, c_pm;
  int          c_lx [4];
  int          c_ly [4];
  int          c_lw [4];
  int          c_lh [4];
  int          cnt  [4];

  logic [33:0] exp_q   [2048];
  logic [3:0]  exp_req [2048];
  int          exp_n;

  always #2 clk = ~clk;

  layer_compositor u0 (
    .clk(clk), .rst_n(rst_n), .frame_w(frame_w), .frame_h(frame_h),
    .bg_color(bg_color), .lyr_en(lyr_en), .lyr_pm(lyr_pm),
    .lyr_x(lyr_x), .lyr_y(lyr_y), .lyr_w(lyr_w), .lyr_h(lyr_h),
    .lyr_pix(lyr_pix), .lyr_req(lyr_req), .out_valid(out_valid),
    .out_ready(out_ready), .out_pix(out_pix), .out_eol(out_eol), .out_eof(out_eof)
  );

  function automatic logic [31:0] src_word(int i, int k);
    logic [31:0] h;
    h = (32'(k) + 32'd1) * 32'h9E3779B1 ^ (32'(i) + 32'd1) * 32'h7F4A7C15;
    h = h ^ (h >> 13);
    if (k % 5 == 0)      h[31:24] = 8'd0;
    else if (k % 5 == 1) h[31:24] = 8'd255;
    return h;
  endfunction

  always_comb begin
    for (int i = 0; i < 4; i++) lyr_pix[32*i +: 32] = src_word(i, cnt[i]);
  end

  initial begin
    for (int i = 0; i < 4; i++) cnt[i] = 0;
    forever begin
      @(posedge clk);
      for (int i = 0; i < 4; i++)
        if (!rst_n) cnt[i] <= 0;
        else if (lyr_req[i]) cnt[i] <= cnt[i] + 1;
    end
  end

  function automatic int rdiv(int p);
    return (2 * p + 255) / 510;
  endfunction

  function automatic logic [31:0] ref_mix(logic [31:0] d, logic [31:0] s, bit pm);
    int sa, v;
    logic [31:0] r;
    sa = int'(s[31:24]);
    v = rdiv(int'(d[31:24]) * (255 - sa)) + sa;
    r[31:24] = 8'(v > 255 ? 255 : v);
    for (int c = 0; c < 3; c++) begin
      v = rdiv(int'(d[8*c +: 8]) * (255 - sa)) + (pm ? int'(s[8*c +: 8]) : rdiv(int'(s[8*c +: 8]) * sa));
      r[8*c +: 8] = 8'(v > 255 ? 255 : v);
    end
    return r;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic apply_cfg();
    frame_w = 12'(c_w);
    frame_h = 12'(c_h);
    bg_color = c_bg;
    lyr_en = c_en;
    lyr_pm = c_pm;
    for (int i = 0; i < 4; i++) begin
      lyr_x[12*i +: 12] = 12'(c_lx[i]);
      lyr_y[12*i +: 12] = 12'(c_ly[i]);
      lyr_w[12*i +: 12] = 12'(c_lw[i]);
      lyr_h[12*i +: 12] = 12'(c_lh[i]);
    end
  endtask

  task automatic clear_cfg(int w, int h, logic [31:0] bg);
    c_w = w; c_h = h; c_bg = bg; c_en = 4'b0; c_pm = 4'b0;
    for (int i = 0; i < 4; i++) begin
      c_lx[i] = 0; c_ly[i] = 0; c_lw[i] = w; c_lh[i] = h;
    end
  endtask

  task automatic set_layer(int i, bit pm, int x, int y, int w, int h);
    c_en[i] = 1'b1; c_pm[i] = pm;
    c_lx[i] = x; c_ly[i] = y; c_lw[i] = w; c_lh[i] = h;
  endtask

  task automatic build_model();
    int k [4];
    int ex, ey, idx;
    logic [31:0] d;
    for (int i = 0; i < 4; i++) k[i] = 0;
    idx = 0;
    for (int y = 0; y < c_h; y++)
      for (int x = 0; x < c_w; x++) begin
        d = c_bg;
        exp_req[idx] = 4'b0;
        for (int i = 0; i < 4; i++) begin
          ex = c_lx[i] > c_w - 1 ? c_w - 1 : c_lx[i];
          ey = c_ly[i] > c_h - 1 ? c_h - 1 : c_ly[i];
          if (c_en[i] && x >= ex && x < ex + c_lw[i] && y >= ey && y < ey + c_lh[i]) begin
            d = ref_mix(d, src_word(i, k[i]), c_pm[i]);
            k[i]++;
            exp_req[idx][i] = 1'b1;
          end
        end
        exp_q[idx] = {(x == c_w - 1) && (y == c_h - 1), x == c_w - 1, d};
        idx++;
      end
    exp_n = idx;
  endtask

  task automatic run_case(string tag, int rdy_pct, bit req_mode, int scramble_at);
    int idx, n;
    bit stall;
    logic [33:0] held;
    build_model();
    @(negedge clk);
    rst_n = 1'b0;
    out_ready = 1'b0;
    apply_cfg();
    @(negedge clk);
    @(negedge clk);
    chk(!out_valid && lyr_req == 4'b0, "R12", {59'd0, out_valid, lyr_req}, 64'd0);
    rst_n = 1'b1;
    idx = 0; n = 0; stall = 0; held = '0;
    while (idx < exp_n && n < 20000) begin
      @(negedge clk);
      n++;
      if (n == scramble_at) begin
        frame_w = 12'($urandom_range(1, 30));
        frame_h = 12'($urandom_range(1, 30));
        bg_color = $urandom; lyr_en = 4'($urandom); lyr_pm = 4'($urandom);
        lyr_x = {16'($urandom), $urandom}; lyr_y = {16'($urandom), $urandom};
        lyr_w = {16'($urandom), $urandom}; lyr_h = {16'($urandom), $urandom};
      end
      if (req_mode && n <= exp_n)
        chk(lyr_req == exp_req[n-1], "R8", 64'(lyr_req), 64'(exp_req[n-1]));
      if (stall) begin
        chk({out_eof, out_eol, out_pix} == held && out_valid, "R11", 64'({out_eof, out_eol, out_pix}), 64'(held));
        stall = 0;
      end
      out_ready = ($urandom % 100) < rdy_pct;
      if (out_valid) begin
        if (out_ready) begin
          chk({out_eof, out_eol, out_pix} == exp_q[idx], tag, 64'({out_eof, out_eol, out_pix}), 64'(exp_q[idx]));
          idx++;
        end else begin
          held = {out_eof, out_eol, out_pix};
          stall = 1;
        end
      end
    end
    chk(idx == exp_n, "R9 frame length", 64'(idx), 64'(exp_n));
    out_ready = 1'b0;
  endtask

  task automatic rand_cfg();
    c_w = $urandom_range(1, 20);
    c_h = $urandom_range(1, 12);
    c_bg = $urandom;
    c_en = 4'($urandom);
    c_pm = 4'($urandom);
    for (int i = 0; i < 4; i++) begin
      c_lx[i] = $urandom_range(0, 24);
      c_ly[i] = $urandom_range(0, 14);
      c_lw[i] = $urandom_range(0, 10);
      c_lh[i] = $urandom_range(0, 8);
    end
  endtask

  initial begin
    #(190000 * 4);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    clear_cfg(4, 4, 32'h0);
    apply_cfg();

    // R4 R6: only the background, every layer disabled
    clear_cfg(5, 3, 32'h80402010);
    run_case("R4 R6", 100, 1, 0);

    // R1 R3: one straight layer over the whole frame
    clear_cfg(6, 4, 32'hC0336699);
    set_layer(0, 0, 0, 0, 6, 4);
    run_case("R1 R3", 70, 0, 0);

    // R2 R3: premultiplied layer on stage C
    clear_cfg(7, 3, 32'hFF808080);
    set_layer(2, 1, 1, 0, 5, 3);
    run_case("R2 R3", 70, 0, 0);

    // R5: four overlapping layers, mixed modes
    clear_cfg(8, 5, 32'h40102030);
    set_layer(0, 0, 0, 0, 8, 5);
    set_layer(1, 1, 1, 1, 6, 3);
    set_layer(2, 0, 2, 0, 4, 5);
    set_layer(3, 1, 3, 2, 5, 3);
    run_case("R5", 60, 0, 0);

    // R7: offsets beyond the frame clamp to the last column and row
    clear_cfg(8, 4, 32'h11223344);
    set_layer(1, 0, 50, 1, 3, 2);
    set_layer(3, 0, 2, 99, 3, 3);
    run_case("R7", 80, 0, 0);

    // R8 R6: request pattern, with a zero-size layer and a disabled layer
    clear_cfg(9, 4, 32'h00000000);
    set_layer(0, 0, 2, 1, 4, 2);
    set_layer(1, 0, 3, 0, 0, 4);
    set_layer(2, 1, 0, 3, 9, 1);
    c_en[2] = 1'b0;
    set_layer(3, 0, 7, 2, 5, 5);
    run_case("R8 R6", 100, 1, 0);

    // R9: single-pixel frame
    clear_cfg(1, 1, 32'hA5A5A5A5);
    set_layer(3, 0, 0, 0, 1, 1);
    run_case("R9", 50, 0, 0);

    // R9: wide single line
    clear_cfg(2000, 1, 32'h7F00FF00);
    set_layer(0, 0, 100, 0, 900, 1);
    set_layer(1, 1, 500, 0, 1400, 1);
    run_case("R9", 90, 0, 0);

    // R10: configuration inputs scrambled mid-frame
    clear_cfg(10, 6, 32'h55AA55AA);
    set_layer(0, 0, 1, 1, 5, 4);
    set_layer(2, 1, 4, 2, 6, 4);
    run_case("R10", 70, 0, 3);

    // R11: heavy back-pressure
    rand_cfg();
    run_case("R11 R1", 25, 0, 0);

    for (int t = 0; t < 24; t++) begin
      rand_cfg();
      run_case("R1 R2 R3 R5 R7", 70, 0, 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule